// File: doc/BRIEF.md
# Capture Arm and Trigger Controller

This block sequences a logic-capture engine through its life cycle: waiting, armed, triggered and finished. Arming comes from a level-sensitive run input or a one-cycle arm request from the host. Once armed, the block watches a data word and compares it with a reference pattern under a bit mask. A match counts only when the trigger-enable input allows it. A separate external trigger input bypasses that enable. Both trigger sources count only in cycles where the sample-valid qualifier is high.

After a trigger the block waits for the capture engine to report that capture is complete, then holds a finished state. It returns to waiting when the host acknowledges and run is low. The block drives three status outputs. At most one of them is high at a time, and each follows the registered state.

Top module: `arm_trig_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, armed_o, triggered_o and done_o are all 0.
- R2: In the waiting state, run_i high at a rising clock edge raises armed_o after that edge.
- R3: In the waiting state, a host_arm_i pulse arms the block in the same way. With run_i and host_arm_i both low, the block stays waiting whatever the data and trigger inputs do.
- R4: While armed, an edge with smp_vld_i=1, trig_en_i=1 and (data_i & mask_i) == (pattern_i & mask_i) moves the block to triggered: triggered_o=1 and armed_o=0 after the edge.
- R5: While armed, a pattern match with trig_en_i=0 and ext_trig_i=0 leaves the block armed.
- R6: While armed, ext_trig_i=1 with smp_vld_i=1 triggers the block even when trig_en_i=0.
- R7: While armed, smp_vld_i=0 blocks both trigger sources, and the block stays armed.
- R8: Trigger inputs have no effect unless the block is armed. Only the first trigger after arming is acted on, and later triggers leave triggered_o as it is.
- R9: While triggered, cap_done_i=1 at an edge moves the block to finished (done_o=1, triggered_o=0).
- R10: While finished, the block returns to waiting (all status outputs 0) only at an edge with done_ack_i=1 and run_i=0. An acknowledge while run_i=1 leaves done_o high.
- R11: Bits with mask_i=0 are left out of the comparison, so an all-zero mask matches any data.
- R12: At most one of armed_o, triggered_o and done_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Level arm request |
| host_arm_i | input | 1 | Host arm command pulse |
| smp_vld_i | input | 1 | Sample-valid qualifier for trigger evaluation (tie to 1 if unused) |
| trig_en_i | input | 1 | Enables the pattern trigger (tie to 1 if unused) |
| ext_trig_i | input | 1 | External trigger that bypasses trig_en_i (tie to 0 if unused) |
| data_i | input | DATA_W | Sampled data word |
| pattern_i | input | DATA_W | Reference pattern |
| mask_i | input | DATA_W | Compare mask, 1 = bit compared |
| cap_done_i | input | 1 | Capture engine finished |
| done_ack_i | input | 1 | Host acknowledge of finished capture |
| armed_o | output | 1 | Block is armed |
| triggered_o | output | 1 | Trigger taken, capture running |
| done_o | output | 1 | Capture finished, awaiting acknowledge |

## Verification
The bench drives a matching pattern while the block is waiting, while it is triggered and while it is finished. A design that listened to triggers outside the armed state would jump states there. It raises the external trigger with the trigger enable low, and separately with the sample qualifier low. A design that routed the external trigger through the enable, or the enable around the qualifier, would stay armed in the first case or trigger in the second. It acknowledges completion with run still high, and a design that ignored run on exit would drop done_o too early. It also runs partial and all-zero masks, which catch a comparison that ignores the mask or applies it to only one side.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2,
    ST_DONE  = 2'd3
  } atc_state_e;
endpackage

// File: rtl/atc_match.sv
module atc_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              match_o
);
  logic [DATA_W-1:0] bit_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // unmasked bits always agree
    assign bit_ok[i] = ~mask_i[i] | (data_i[i] ~^ pattern_i[i]);
  end

  assign match_o = &bit_ok;
endmodule

// File: rtl/atc_trig_sel.sv
module atc_trig_sel (
  input  logic smp_vld_i,
  input  logic trig_en_i,
  input  logic ext_trig_i,
  input  logic match_i,
  output logic hit_o
);
  logic int_hit;

  assign int_hit = trig_en_i & match_i;
  // external path skips trig_en_i, both respect the sample qualifier
  assign hit_o   = smp_vld_i & (int_hit | ext_trig_i);
endmodule

// File: rtl/arm_trig_ctrl.sv
module arm_trig_ctrl
  import atc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              host_arm_i,
  input  logic              smp_vld_i,
  input  logic              trig_en_i,
  input  logic              ext_trig_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              cap_done_i,
  input  logic              done_ack_i,
  output logic              armed_o,
  output logic              triggered_o,
  output logic              done_o
);
  atc_state_e state_q, state_d;
  logic       match, hit;

  atc_match #(.DATA_W(DATA_W)) u_match (
    .data_i    (data_i),
    .pattern_i (pattern_i),
    .mask_i    (mask_i),
    .match_o   (match)
  );

  atc_trig_sel u_sel (
    .smp_vld_i  (smp_vld_i),
    .trig_en_i  (trig_en_i),
    .ext_trig_i (ext_trig_i),
    .match_i    (match),
    .hit_o      (hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (run_i || host_arm_i)      state_d = ST_ARMED;
      ST_ARMED: if (hit)                      state_d = ST_TRIG;
      ST_TRIG:  if (cap_done_i)               state_d = ST_DONE;
      ST_DONE:  if (done_ack_i && !run_i)     state_d = ST_IDLE;
      default:                                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o     = (state_q == ST_ARMED);
  assign triggered_o = (state_q == ST_TRIG);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/arm_trig_ctrl_chk.sv
module arm_trig_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              host_arm_i,
  input logic              smp_vld_i,
  input logic              trig_en_i,
  input logic              ext_trig_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] pattern_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              cap_done_i,
  input logic              done_ack_i,
  input logic              armed_o,
  input logic              triggered_o,
  input logic              done_o
);
  logic idle;
  assign idle = !armed_o && !triggered_o && !done_o;

  assert_onehot_status_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({armed_o, triggered_o, done_o}));

  assert_arm_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && (run_i || host_arm_i) |=> armed_o);

  assert_stay_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !run_i && !host_arm_i |=> idle);

  assert_pattern_trig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && smp_vld_i && trig_en_i && ((data_i & mask_i) == (pattern_i & mask_i))
    |=> triggered_o);

  assert_en_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && !trig_en_i && !ext_trig_i |=> armed_o);

  assert_ext_trig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && smp_vld_i && ext_trig_i |=> triggered_o);

  assert_vld_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && !smp_vld_i |=> armed_o);

  assert_trig_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    triggered_o && !cap_done_i |=> triggered_o);

  assert_cap_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    triggered_o && cap_done_i |=> done_o);

  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !(done_ack_i && !run_i) |=> done_o);

  assert_done_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_ack_i && !run_i |=> idle);
endmodule

bind arm_trig_ctrl arm_trig_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_arm_trig_ctrl.sv
module sim_arm_trig_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, arm = 0, vld = 1, ten = 1, ext = 0, cdone = 0, ack = 0;
  logic [W-1:0] data = '0, pat = 8'hA5, mask = 8'hFF;
  logic armed, trig, done;

  int tests = 0, fails = 0;
  int ms = 0;  // 0 wait, 1 armed, 2 triggered, 3 finished

  always #4 clk = ~clk;

  arm_trig_ctrl #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .host_arm_i(arm),
    .smp_vld_i(vld), .trig_en_i(ten), .ext_trig_i(ext),
    .data_i(data), .pattern_i(pat), .mask_i(mask),
    .cap_done_i(cdone), .done_ack_i(ack),
    .armed_o(armed), .triggered_o(trig), .done_o(done)
  );

  task automatic check(input string tag);
    logic [2:0] exp, act;
    exp = {ms == 1, ms == 2, ms == 3};
    act = {armed, trig, done};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {armed,triggered,done} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    case (ms)
      0: if (run || arm) ms = 1;
      1: if (vld && ((ten && ((data & mask) == (pat & mask))) || ext)) ms = 2;
      2: if (cdone) ms = 3;
      3: if (ack && !run) ms = 0;
      default: ms = 0;
    endcase
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // triggers while waiting are ignored
    data = 8'hA5; ext = 1;
    cyc("R8"); cyc("R3");
    ext = 0;
    cyc("R3");

    // host arm pulse
    arm = 1; cyc("R3"); arm = 0;
    // pattern match with enable low
    ten = 0; cyc("R5"); cyc("R5");
    // external trigger with qualifier low
    vld = 0; ext = 1; cyc("R7");
    ten = 1; cyc("R7");
    // external trigger with enable low
    vld = 1; ten = 0; cyc("R6");
    // further triggers while triggered
    ten = 1; cyc("R8"); ext = 0; cyc("R8");
    cdone = 1; cyc("R9"); cdone = 0;
    // triggers while finished
    ext = 1; cyc("R8"); ext = 0;
    // ack with run high
    run = 1; ack = 1; cyc("R10"); cyc("R10");
    run = 0; cyc("R10"); ack = 0;
    cyc("R3");

    // run arms, pattern mismatch then match
    run = 1; data = 8'h00; cyc("R2"); run = 0;
    data = 8'h5A; cyc("R4");
    mask = 8'hF0; data = 8'hAC; cyc("R11");
    cdone = 1; cyc("R9"); cdone = 0;
    ack = 1; cyc("R10"); ack = 0;

    // exact match under full mask
    mask = 8'hFF; data = 8'hA4;
    arm = 1; cyc("R3"); arm = 0;
    cyc("R4");
    data = 8'hA5; cyc("R4");
    cdone = 1; cyc("R9"); cdone = 0;
    ack = 1; cyc("R10"); ack = 0;

    // all-zero mask matches anything
    mask = 8'h00; data = 8'h3C;
    run = 1; cyc("R2"); run = 0;
    vld = 0; cyc("R7"); vld = 1;
    cyc("R11");
    cyc("R12");
    cdone = 1; cyc("R9"); cdone = 0;
    ack = 1; cyc("R10"); ack = 0;
    cyc("R12");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule